// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked on-chip request stream and an external byte-wide asynchronous static RAM of 128K locations. Each accepted request performs exactly one access: a write stores one byte and a read returns one byte. The block generates the address, a pair of opposite-polarity chip selects, an active-low output enable, an active-low write enable and a split data path (driven byte, drive enable, returned byte) for a pad-level tri-state buffer. Every strobe comes straight from a state flop. The only timing knowledge is in nanosecond parameters, which are turned into whole clock counts by rounding up.

Requests use a valid/ready stream. A request moves on the rising edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the source keeps `req_valid` high and holds `req_we`, `req_addr` and `req_wdata` steady. Ready drops for the full length of each access, so a waiting request is taken only once. Read results come back as a one-cycle `rd_valid` pulse with no back-pressure, so the consumer must take the byte in that cycle. Between any two accesses the part is deselected for at least one cycle. This gap keeps the bus free of contention when a read is followed by a write.

Top module: `sram_ctrl`

## Requirements
- R1: During reset and in idle, `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0, and `req_ready`=1 once reset is released.
- R2: A request is taken on the edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 for exactly the access length (LW cycles for a write, RL for a read) and returns to 1 after it. A request held waiting is performed once.
- R3: The part is selected (`mem_ce_n`=0 together with `mem_ce`=1) in every cycle of an access, and deselected (`mem_ce_n`=1, `mem_ce`=0) in all other cycles.
- R4: A write (`req_we`=1) has three phases. It starts with one cycle of address and data driven and `mem_we_n`=1. Then `mem_we_n`=0 for WPE cycles. Then `mem_we_n`=1 for WH cycles, with address and data still held. `mem_dq_oe`=1 throughout and drops on the first deselected cycle.
- R5: With C(x)=ceil(x/T_CLK_NS), the cycle counts obey the following rules. WPE = max(C(T_PWE_NS), C(T_SD_NS)-1, C(T_AW_NS)-1). WH = max(1, C(T_WC_NS)-1-WPE). LW = 1+WPE+WH. Hence the write-enable low time is at least C(T_PWE_NS), data and address are steady for at least C(T_SD_NS) and C(T_AW_NS) cycles before write enable rises, and a write keeps the part selected for at least C(T_WC_NS) cycles.
- R6: `mem_oe_n` stays 1 in every write cycle, and `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R7: A read (`req_we`=0) selects the part with `mem_oe_n`=0 and `mem_we_n`=1 for RL = max(ACC, C(T_RC_NS)) cycles, where ACC = max(C(T_AA_NS), C(T_DOE_NS)). The address stays constant for the whole access.
- R8: `mem_dq_in` is sampled on the ACC-th rising edge after the accepting edge. `rd_data` and a one-cycle `rd_valid` pulse are visible in the cycle after that edge.
- R9: At least one deselected cycle, with `mem_oe_n`=1 and the bus released, separates any two accesses, including a read followed by a write.
- R10: A read returns the byte most recently written to that address, including the lowest (0) and highest (17'h1FFFF) addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-cycle read-result strobe |
| rd_data | output | 8 | Read result |
| mem_addr | output | 17 | RAM address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_ce | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the RAM data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Byte seen on the RAM data pins |

## Verification
The strobes, the address and the driven byte change in the first cycle after the accepting edge. `req_ready` falls in that same cycle and rises LW or RL cycles later. `rd_valid` and `rd_data` appear exactly ACC cycles after the accepting edge. The bench keeps a behavioural countdown per access from the nanosecond parameters and compares every output against it at each falling clock edge, so a phase that comes one cycle early or late shows up as a miscompare. The bench's RAM model drives a deliberately wrong byte until the address has been steady for ACC cycles, so a read that samples too early is caught. It also measures the write-enable width, the data and address setup and the selected time, and checks at each write end before it stores the byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  localparam int S_IDLE  = 0;
  localparam int S_RD    = 1;
  localparam int S_WSET  = 2;
  localparam int S_WPUL  = 3;
  localparam int S_WHOLD = 4;
  localparam int NSTATE  = 5;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctrl_cnt.sv
module sram_ctrl_cnt #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          zero
);
  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (!zero) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int WPE   = 4,
  parameter int WHOLD = 1,
  parameter int RL    = 6,
  parameter int ACC   = 6,
  parameter int CW    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [CW-1:0]     cnt,
  input  logic              cnt_zero,
  output logic [NSTATE-1:0] state,
  output logic              accept,
  output logic              cnt_load,
  output logic [CW-1:0]     cnt_val,
  output logic              cap_en
);
  logic [NSTATE-1:0] nxt;

  assign accept = state[S_IDLE] & req_valid;
  assign cap_en = state[S_RD] && (cnt == CW'(RL - ACC));

  always_comb begin
    nxt      = state;
    cnt_load = 1'b0;
    cnt_val  = '0;
    if (accept) begin
      nxt      = '0;
      cnt_load = 1'b1;
      if (req_we) begin
        nxt[S_WSET] = 1'b1;
      end else begin
        nxt[S_RD] = 1'b1;
        cnt_val   = CW'(RL - 1);
      end
    end else if (cnt_zero) begin
      if (state[S_WSET]) begin
        nxt          = '0;
        nxt[S_WPUL]  = 1'b1;
        cnt_load     = 1'b1;
        cnt_val      = CW'(WPE - 1);
      end else if (state[S_WPUL]) begin
        nxt          = '0;
        nxt[S_WHOLD] = 1'b1;
        cnt_load     = 1'b1;
        cnt_val      = CW'(WHOLD - 1);
      end else if (state[S_WHOLD] || state[S_RD]) begin
        nxt          = '0;
        nxt[S_IDLE]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= NSTATE'(1) << S_IDLE;
    else     state <= nxt;
  end

  // R3
  state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(state) == 1);

  // R9
  idle_after_access_chk: assert property (@(posedge clk) disable iff (rst)
    ((state[S_RD] || state[S_WHOLD]) && cnt_zero) |=> state[S_IDLE]);
endmodule

// File: rtl/sram_ctrl_rcap.sv
module sram_ctrl_rcap #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap_en;
      if (cap_en) rd_data <= dq_in;
    end
  end

  // R8
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int T_CLK_NS  = 10,
  parameter int T_WC_NS   = 55,
  parameter int T_PWE_NS  = 40,
  parameter int T_AW_NS   = 45,
  parameter int T_SD_NS   = 25,
  parameter int T_RC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_DOE_NS  = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_ce,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int WCC   = ceil_div(T_WC_NS, T_CLK_NS);
  localparam int PWC   = ceil_div(T_PWE_NS, T_CLK_NS);
  localparam int AWC   = ceil_div(T_AW_NS, T_CLK_NS);
  localparam int SDC   = ceil_div(T_SD_NS, T_CLK_NS);
  localparam int RCC   = ceil_div(T_RC_NS, T_CLK_NS);
  localparam int ACC   = imax(ceil_div(T_AA_NS, T_CLK_NS), ceil_div(T_DOE_NS, T_CLK_NS));
  localparam int WPE   = imax(PWC, imax(SDC - 1, AWC - 1));
  localparam int WHOLD = imax(1, WCC - 1 - WPE);
  localparam int RL    = imax(ACC, RCC);
  localparam int MAXL  = imax(RL, imax(WPE, WHOLD));
  localparam int CW    = $clog2(MAXL + 1);

  logic [NSTATE-1:0] state;
  logic              accept, cnt_load, cnt_zero, cap_en;
  logic [CW-1:0]     cnt, cnt_val;

  sram_ctrl_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val),
    .cnt(cnt), .zero(cnt_zero)
  );

  sram_ctrl_fsm #(.WPE(WPE), .WHOLD(WHOLD), .RL(RL), .ACC(ACC), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .cnt(cnt), .cnt_zero(cnt_zero), .state(state), .accept(accept),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .cap_en(cap_en)
  );

  sram_ctrl_rcap #(.DW(DW)) u_rcap (
    .clk(clk), .rst(rst), .cap_en(cap_en), .dq_in(mem_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  assign req_ready = state[S_IDLE];
  assign mem_ce_n  = state[S_IDLE];
  assign mem_ce    = ~state[S_IDLE];
  assign mem_we_n  = ~state[S_WPUL];
  assign mem_oe_n  = ~state[S_RD];
  assign mem_dq_oe = state[S_WSET] | state[S_WPUL] | state[S_WHOLD];

  // width of the current write-enable low run, for the pulse check
  logic [CW-1:0] we_run;
  always_ff @(posedge clk) begin
    if (rst)            we_run <= '0;
    else if (!mem_we_n) we_run <= we_run + 1'b1;
    else                we_run <= '0;
  end

  // R6
  no_bus_contend_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  // R4
  we_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_ce && mem_dq_oe));

  // R7
  addr_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R2
  ready_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_run == CW'(WPE)));
endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;
  localparam int CLK_NS = 8;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int WCC = cdiv(55, CLK_NS);
  localparam int PWC = cdiv(40, CLK_NS);
  localparam int AWC = cdiv(45, CLK_NS);
  localparam int SDC = cdiv(25, CLK_NS);
  localparam int RCC = cdiv(55, CLK_NS);
  localparam int ACC = mx(cdiv(55, CLK_NS), cdiv(25, CLK_NS));
  localparam int WPE = mx(PWC, mx(SDC - 1, AWC - 1));
  localparam int WH  = mx(1, WCC - 1 - WPE);
  localparam int LW  = 1 + WPE + WH;
  localparam int RL  = mx(ACC, RCC);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  sram_ctrl #(.T_CLK_NS(CLK_NS)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model (per-access countdown) ----------------
  logic [7:0] shadow [int];
  int         busy = 0, rcnt = 0, cur_len = 0;
  bit         cur_we = 0, exp_rv = 0, acc_flag = 0;
  logic [16:0] cur_a = '0;
  logic [7:0]  cur_d = '0, exp_rd = '0;
  logic [7:0]  rq[$];

  always @(posedge clk) begin
    if (rst) begin
      busy = 0; rcnt = 0; exp_rv = 0; acc_flag = 0;
    end else begin
      exp_rv = 0;
      acc_flag = 0;
      if (rcnt > 0) begin
        rcnt--;
        if (rcnt == 0) begin exp_rv = 1; exp_rd = rq.pop_front(); end
      end
      if (busy > 0) busy--;
      else if (req_valid) begin
        acc_flag = 1;
        cur_we = req_we; cur_a = req_addr; cur_d = req_wdata;
        if (req_we) begin
          busy = LW; shadow[int'(req_addr)] = req_wdata;
        end else begin
          busy = RL; rcnt = ACC;
          rq.push_back(shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : 8'h00);
        end
        cur_len = busy;
      end
    end
  end

  // ---------------- output comparison every cycle ----------------
  always @(negedge clk) begin
    if (rst) begin
      chk(mem_ce_n == 1'b1 && mem_ce == 1'b0, "R1", "chip selects in reset",
          {mem_ce_n, mem_ce}, 2'b10);
      chk(mem_we_n && mem_oe_n && !mem_dq_oe, "R1", "strobes in reset",
          {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b110);
    end else begin
      automatic bit sel = (busy > 0);
      automatic int k = cur_len - busy + 1;
      automatic bit e_we_n = !(sel && cur_we && k >= 2 && k <= 1 + WPE);
      chk(req_ready == (busy == 0), "R2", "req_ready", req_ready, busy == 0);
      chk({mem_ce_n, mem_ce} == (sel ? 2'b01 : 2'b10), "R3", "chip selects",
          {mem_ce_n, mem_ce}, sel ? 2'b01 : 2'b10);
      chk(mem_we_n == e_we_n, "R4", "write enable", mem_we_n, e_we_n);
      chk(mem_dq_oe == (sel && cur_we), "R4", "data drive", mem_dq_oe, sel && cur_we);
      chk(mem_oe_n == !(sel && !cur_we), "R7", "output enable", mem_oe_n, !(sel && !cur_we));
      if (sel && cur_we)
        chk(mem_dq_out == cur_d && mem_addr == cur_a, "R4", "write addr/data",
            {mem_addr, mem_dq_out}, {cur_a, cur_d});
      if (sel && !cur_we)
        chk(mem_addr == cur_a, "R7", "read address", mem_addr, cur_a);
      chk(rd_valid == exp_rv, "R8", "rd_valid timing", rd_valid, exp_rv);
      if (exp_rv && rd_valid)
        chk(rd_data == exp_rd, "R10", "read data", rd_data, exp_rd);
    end
  end

  // ---------------- behavioural RAM with timing checks ----------------
  logic [7:0]  ram [int];
  bit          p_sel = 0, p_we_low = 0, p_dq_oe = 0, was_w = 0;
  int          addr_age = 0, data_age = 0, we_age = 0, sel_age = 0;
  logic [16:0] last_a = '0, w_a = '0;
  logic [7:0]  last_d = '0, w_d = '0;

  function automatic logic [7:0] ram_rd(input logic [16:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      automatic bit sel = !mem_ce_n && mem_ce;
      automatic bit wlo = !mem_we_n;
      chk(!(mem_dq_oe && !mem_oe_n), "R6", "bus contention", mem_dq_oe, 0);
      if (sel) begin
        addr_age = (p_sel && mem_addr == last_a) ? addr_age + 1 : 1;
        sel_age  = p_sel ? sel_age + 1 : 1;
        if (!p_sel) was_w = 0;
      end else addr_age = 0;
      data_age = (mem_dq_oe && p_dq_oe && mem_dq_out == last_d) ? data_age + 1
               : (mem_dq_oe ? 1 : 0);
      if (wlo) begin
        we_age = p_we_low ? we_age + 1 : 1;
        w_a = mem_addr; w_d = mem_dq_out; was_w = 1;
        chk(mem_oe_n == 1'b1, "R6", "output enable during write", mem_oe_n, 1);
      end else if (p_we_low) begin
        chk(we_age >= PWC, "R5", "write pulse width", we_age, PWC);
        chk(data_age - 1 >= SDC, "R5", "data setup", data_age - 1, SDC);
        chk(addr_age - 1 >= AWC, "R5", "address valid to write end", addr_age - 1, AWC);
        ram[int'(w_a)] = w_d;
      end
      if (!sel && p_sel)
        chk(sel_age >= (was_w ? WCC : RCC), "R5", "selected cycle time",
            sel_age, was_w ? WCC : RCC);
      if (sel && !mem_oe_n && mem_we_n)
        mem_dq_in = (addr_age >= ACC) ? ram_rd(mem_addr) : ~ram_rd(mem_addr);
      else
        mem_dq_in = 8'hEE;
      p_sel = sel; p_we_low = wlo; p_dq_oe = mem_dq_oe;
      last_a = mem_addr; last_d = mem_dq_out;
    end
  end

  // ---------------- stimulus ----------------
  task automatic op(input bit we, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    forever begin
      @(posedge clk); #1;
      if (acc_flag) break;
    end
    req_valid = 1'b0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  logic [16:0] addrs[$];

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R10: boundary addresses
    op(1, 17'h00000, 8'h3C);
    op(1, 17'h1FFFF, 8'hC3);
    op(0, 17'h00000, 8'h00);
    op(0, 17'h1FFFF, 8'h00);
    // R9: read immediately followed by a write, then read back
    op(0, 17'h00000, 8'h00);
    op(1, 17'h00000, 8'h5A);
    op(0, 17'h00000, 8'h00);
    // R2: overwrite with requests held waiting
    op(1, 17'h1FFFF, 8'h01);
    op(1, 17'h1FFFF, 8'hFE);
    op(0, 17'h1FFFF, 8'h00);
    // R10: random write-then-read
    for (int i = 0; i < 40; i++) begin
      automatic logic [16:0] a = 17'($urandom);
      addrs.push_back(a);
      op(1, a, 8'($urandom));
    end
    foreach (addrs[i]) op(0, addrs[i], 8'h00);
    // mixed random traffic
    for (int i = 0; i < 60; i++) begin
      automatic int j = $urandom_range(0, addrs.size() - 1);
      op($urandom_range(0, 1) == 1, addrs[j], 8'($urandom));
    end
    repeat (RL + LW + 4) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule